// File: doc/BRIEF.md
# Byte/Word ROM Output Steering

This block holds the control and output-steering logic of a read-only memory that can be organised as 16-bit words or as 8-bit bytes. It sits behind a behavioural memory array, either in a testbench or as a stand-in for the memory on an FPGA. A mode input picks the organisation. In word mode the address input is the full word address. In byte mode the same address input gives the upper bits of a byte address, and the lowest byte-address bit comes in on the pin that carries data bit 15 in word mode.

A chip-select input and an output-enable input decide whether the data lanes are driven. The output-enable polarity is fixed when the block is built, with one of three settings: active-low, active-high, or ignored. The block does not drive bidirectional pads. Instead it gives a 16-bit data value and a 16-bit per-bit drive-enable vector, and the surrounding pad logic or bench turns these into tri-state behaviour.

The array contents come from a fixed arithmetic pattern of the word index, with a seed set by a parameter. All outputs are registered once.

Top module: `drom_byteword_ctrl`

## Requirements
- R1: While reset is asserted, `data_o`, `drive_en_o` and `array_idx_o` are all zero.
- R2: Every output reflects the inputs sampled at the previous rising clock edge, one register stage deep.
- R3: With `chip_sel_n_i` high, `drive_en_o` is 0x0000 and `data_o` is 0x0000 whatever level `oe_pin_i` has.
- R4: With OE_OPT = OE_ACT_LOW and the chip selected, the lanes are driven when `oe_pin_i` is 0 and are all undriven (drive 0x0000, data 0x0000) when it is 1.
- R5: With OE_OPT = OE_ACT_HIGH and the chip selected, the lanes are driven when `oe_pin_i` is 1 and are all undriven when it is 0.
- R6: With OE_OPT = OE_IGNORED, the lanes are driven whenever the chip is selected, at either level of `oe_pin_i`.
- R7: In word mode (`word_mode_i` = 1), when driven, `drive_en_o` is 0xFFFF and `data_o` is the full 16-bit word at the word index `addr_i`.
- R8: In byte mode (`word_mode_i` = 0), when driven, `drive_en_o` is 0x00FF. Bits 7:0 of `data_o` carry bits 7:0 of the addressed word when `lsb_pin_i` = 0, and bits 15:8 when `lsb_pin_i` = 1. Bits 15:8 of `data_o` are 0.
- R9: `array_idx_o` takes the value of `addr_i` whenever the chip is selected, and holds its value while `chip_sel_n_i` is high.
- R10: In word mode, the level on `lsb_pin_i` has no effect on `data_o` or `drive_en_o`.
- R11: The word at index i is ((i × 0x9E37) XOR (i >> 16)) mod 2^16, XORed with SEED. SEED defaults to 0x5A3C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_mode_i | input | 1 | 1 = 16-bit word organisation, 0 = 8-bit byte organisation |
| chip_sel_n_i | input | 1 | Chip select, active low; high means standby |
| oe_pin_i | input | 1 | Output enable; polarity set by OE_OPT |
| addr_i | input | ADDR_W | Word address, or upper bits of the byte address |
| lsb_pin_i | input | 1 | Lowest byte-address bit in byte mode; the data-bit-15 pin in word mode |
| data_o | output | 16 | Value presented on the data lanes |
| drive_en_o | output | 16 | Per-lane drive enable; 0 means high impedance |
| array_idx_o | output | ADDR_W | Word index presented to the memory array |

## Verification
The hardest situation to reach is one where the three output-enable builds disagree for the same stimulus. The same chip-selected cycle must leave the active-low build driving, the active-high build quiet and the ignoring build driving, and then the reverse. The bench gets there by running one instance of each build side by side on shared inputs and switching `oe_pin_i` while the chip stays selected. Each item in the scoreboard carries the expected value for all three builds. A second corner is a run of address changes while the chip is deselected. The held index must then stay at its last selected value and jump straight to the new address when the chip is selected again.

// File: rtl/drom_pkg.sv
package drom_pkg;

    localparam int unsigned LANE_W = 16;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        OE_ACT_LOW  = 2'd0,
        OE_ACT_HIGH = 2'd1,
        OE_IGNORED  = 2'd2
    } oe_opt_e;

    typedef struct packed {
        logic [LANE_W-1:0] data;
        logic [LANE_W-1:0] drv;
    } lane_state_t;

    // Content generator of the behavioural array (word granularity)
    function automatic logic [LANE_W-1:0] pattern_word(input logic [31:0] idx,
                                                       input logic [LANE_W-1:0] seed);
        return 16'((idx * 32'h0000_9E37) ^ (idx >> 16)) ^ seed;
    endfunction

endpackage

// File: rtl/drom_enable_decode.sv
module drom_enable_decode
    import drom_pkg::*;
#(
    parameter oe_opt_e OE_OPT = OE_ACT_LOW
) (
    input  logic chip_sel_n_i,
    input  logic oe_pin_i,
    output logic chip_on_o,
    output logic drive_ok_o
);
    localparam logic OE_LEVEL     = (OE_OPT == OE_ACT_HIGH);
    localparam logic OE_DONTCARE  = (OE_OPT == OE_IGNORED);

    assign chip_on_o  = ~chip_sel_n_i;
    assign drive_ok_o = chip_on_o & (OE_DONTCARE | (oe_pin_i == OE_LEVEL));
endmodule

// File: rtl/drom_pattern_array.sv
module drom_pattern_array
    import drom_pkg::*;
#(
    parameter int unsigned       ADDR_W = 21,
    parameter logic [LANE_W-1:0] SEED   = 16'h5A3C
) (
    input  logic [ADDR_W-1:0] idx_i,
    output logic [LANE_W-1:0] word_o
);
    assign word_o = pattern_word(32'(idx_i), SEED);
endmodule

// File: rtl/drom_lane_steer.sv
module drom_lane_steer
    import drom_pkg::*;
(
    input  logic [LANE_W-1:0] word_i,
    input  logic              wide_i,
    input  logic              lsb_i,
    input  logic              drive_ok_i,
    output lane_state_t       lane_o
);
    logic [BYTE_W-1:0] byte_pick;
    logic [LANE_W-1:0] drv_v;
    logic [LANE_W-1:0] data_v;

    assign byte_pick = lsb_i ? word_i[LANE_W-1:BYTE_W] : word_i[BYTE_W-1:0];

    for (genvar b = 0; b < LANE_W; b++) begin : g_lane
        if (b < BYTE_W) begin : g_low
            assign drv_v[b]  = drive_ok_i;
            assign data_v[b] = drive_ok_i & (wide_i ? word_i[b] : byte_pick[b]);
        end else begin : g_high
            assign drv_v[b]  = drive_ok_i & wide_i;
            assign data_v[b] = drv_v[b] & word_i[b];
        end
    end

    assign lane_o = '{data: data_v, drv: drv_v};
endmodule

// File: rtl/drom_byteword_ctrl.sv
module drom_byteword_ctrl
    import drom_pkg::*;
#(
    parameter int unsigned       ADDR_W = 21,
    parameter logic [LANE_W-1:0] SEED   = 16'h5A3C,
    parameter oe_opt_e           OE_OPT = OE_ACT_LOW
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              word_mode_i,
    input  logic              chip_sel_n_i,
    input  logic              oe_pin_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              lsb_pin_i,
    output logic [LANE_W-1:0] data_o,
    output logic [LANE_W-1:0] drive_en_o,
    output logic [ADDR_W-1:0] array_idx_o
);
    localparam logic [LANE_W-1:0] ALL_LANES  = '1;
    localparam logic [LANE_W-1:0] BYTE_LANES = LANE_W'((1 << BYTE_W) - 1);

    typedef struct packed {
        lane_state_t       lane;
        logic [ADDR_W-1:0] idx;
    } ctrl_state_t;

    ctrl_state_t       state_d, state_q;
    logic              chip_on, drive_ok;
    logic [LANE_W-1:0] word_rd;
    lane_state_t       lane_nx;

    drom_enable_decode #(.OE_OPT(OE_OPT)) u_decode (
        .chip_sel_n_i (chip_sel_n_i),
        .oe_pin_i     (oe_pin_i),
        .chip_on_o    (chip_on),
        .drive_ok_o   (drive_ok)
    );

    drom_pattern_array #(.ADDR_W(ADDR_W), .SEED(SEED)) u_array (
        .idx_i  (addr_i),
        .word_o (word_rd)
    );

    drom_lane_steer u_steer (
        .word_i     (word_rd),
        .wide_i     (word_mode_i),
        .lsb_i      (lsb_pin_i),
        .drive_ok_i (drive_ok),
        .lane_o     (lane_nx)
    );

    always_comb begin
        state_d      = state_q;
        state_d.lane = lane_nx;
        if (chip_on) begin
            state_d.idx = addr_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign data_o      = state_q.lane.data;
    assign drive_en_o  = state_q.lane.drv;
    assign array_idx_o = state_q.idx;

    AST_STANDBY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chip_sel_n_i |=> (drive_en_o == '0)); // R3
    AST_UNDRIVEN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drive_en_o == '0) |-> (data_o == '0)); // R3
    AST_WORD_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drive_ok && word_mode_i) |=> (drive_en_o == ALL_LANES)); // R7
    AST_BYTE_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drive_ok && !word_mode_i) |=> (drive_en_o == BYTE_LANES)); // R8
    AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chip_sel_n_i |=> $stable(array_idx_o)); // R9
    AST_IDX_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !chip_sel_n_i |=> (array_idx_o == $past(addr_i))); // R9

    if (OE_OPT == OE_ACT_LOW) begin : g_ast_low
        AST_OE_LOW_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
            oe_pin_i |=> (drive_en_o == '0)); // R4
    end else if (OE_OPT == OE_ACT_HIGH) begin : g_ast_high
        AST_OE_HIGH_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !oe_pin_i |=> (drive_en_o == '0)); // R5
    end else begin : g_ast_ign
        AST_OE_IGNORED_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !chip_sel_n_i |=> (drive_en_o != '0)); // R6
    end
endmodule

// File: tb/drom_byteword_ctrl_tb_top.sv
`timescale 1ns/1ps
module drom_byteword_ctrl_tb_top;
    import drom_pkg::*;

    localparam int unsigned AW   = 21;
    localparam logic [15:0] SEED = 16'h5A3C;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          wide = 1'b1, ce_n = 1'b0, oe = 1'b0, lsb = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   d_lo, e_lo, d_hi, e_hi, d_x, e_x;
    logic [AW-1:0] i_lo, i_hi, i_x;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [AW-1:0] idx_model = '0;

    always #2 clk = ~clk;

    drom_byteword_ctrl #(.ADDR_W(AW), .SEED(SEED), .OE_OPT(OE_ACT_LOW)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .word_mode_i(wide), .chip_sel_n_i(ce_n),
        .oe_pin_i(oe), .addr_i(addr), .lsb_pin_i(lsb),
        .data_o(d_lo), .drive_en_o(e_lo), .array_idx_o(i_lo));
    drom_byteword_ctrl #(.ADDR_W(AW), .SEED(SEED), .OE_OPT(OE_ACT_HIGH)) dut_hi_i (
        .clk_i(clk), .rst_ni(rst_ni), .word_mode_i(wide), .chip_sel_n_i(ce_n),
        .oe_pin_i(oe), .addr_i(addr), .lsb_pin_i(lsb),
        .data_o(d_hi), .drive_en_o(e_hi), .array_idx_o(i_hi));
    drom_byteword_ctrl #(.ADDR_W(AW), .SEED(SEED), .OE_OPT(OE_IGNORED)) dut_x_i (
        .clk_i(clk), .rst_ni(rst_ni), .word_mode_i(wide), .chip_sel_n_i(ce_n),
        .oe_pin_i(oe), .addr_i(addr), .lsb_pin_i(lsb),
        .data_o(d_x), .drive_en_o(e_x), .array_idx_o(i_x));

    typedef struct {
        logic [15:0]   d [3];
        logic [15:0]   e [3];
        logic [AW-1:0] idx;
        string         tag;
    } exp_t;

    exp_t sb_q[$];

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Model per R11
    function automatic logic [15:0] model_word(logic [AW-1:0] a);
        logic [31:0] w;
        w = ({11'b0, a} * 32'h9E37) ^ ({11'b0, a} >> 16);
        return w[15:0] ^ SEED;
    endfunction

    // Model per R3..R8, R10; opt 0=act low (R4), 1=act high (R5), 2=ignored (R6)
    task automatic model_lane(int opt, logic c_n, logic o, logic w, logic [AW-1:0] a,
                              logic l, output logic [15:0] dv, output logic [15:0] ev);
        logic on;
        logic [15:0] word;
        on = !c_n && ((opt == 0) ? !o : (opt == 1) ? o : 1'b1);
        word = model_word(a);
        if (!on) begin
            dv = 16'h0; ev = 16'h0;
        end else if (w) begin
            dv = word; ev = 16'hFFFF;
        end else begin
            dv = {8'h00, (l ? word[15:8] : word[7:0])}; ev = 16'h00FF;
        end
    endtask

    task automatic drive(logic c_n, logic o, logic w, logic [AW-1:0] a, logic l, string tag);
        exp_t it;
        @(negedge clk);
        ce_n = c_n; oe = o; wide = w; addr = a; lsb = l;
        for (int k = 0; k < 3; k++) model_lane(k, c_n, o, w, a, l, it.d[k], it.e[k]);
        if (!c_n) idx_model = a;
        it.idx = idx_model;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: outputs are checked one edge after the inputs were driven (R2)
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                chk({it.tag, " R4"}, "lo.drv",  32'(e_lo), 32'(it.e[0]));
                chk({it.tag, " R4"}, "lo.data", 32'(d_lo), 32'(it.d[0]));
                chk({it.tag, " R5"}, "hi.drv",  32'(e_hi), 32'(it.e[1]));
                chk({it.tag, " R5"}, "hi.data", 32'(d_hi), 32'(it.d[1]));
                chk({it.tag, " R6"}, "x.drv",   32'(e_x),  32'(it.e[2]));
                chk({it.tag, " R6"}, "x.data",  32'(d_x),  32'(it.d[2]));
                chk({it.tag, " R9"}, "idx",     32'(i_lo), 32'(it.idx));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state with active-looking inputs
        wide = 1'b1; ce_n = 1'b0; oe = 1'b1; addr = 21'h0ABCD;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "lo.drv", 32'(e_lo), 32'h0);
        chk("R1", "hi.drv", 32'(e_hi), 32'h0);
        chk("R1", "hi.data", 32'(d_hi), 32'h0);
        chk("R1", "x.data", 32'(d_x), 32'h0);
        chk("R1", "idx", 32'(i_x), 32'h0);
        @(negedge clk);
        rst_ni = 1'b1;

        // R7 / R11: word mode over several indices
        drive(0, 0, 1, 21'h000000, 0, "R7");
        drive(0, 0, 1, 21'h000001, 0, "R11");
        drive(0, 0, 1, 21'h01ABCD, 0, "R11");
        drive(0, 0, 1, 21'h1FFFFF, 0, "R11");
        // R8: byte mode lane selection
        drive(0, 0, 0, 21'h012345, 0, "R8");
        drive(0, 0, 0, 21'h012345, 1, "R8");
        drive(0, 0, 0, 21'h1FFFFF, 1, "R8");
        // R10: word mode, shared pin toggled on one address
        drive(0, 0, 1, 21'h000777, 0, "R10");
        drive(0, 0, 1, 21'h000777, 1, "R10");
        // R4 / R5 / R6: enable level swept with chip selected
        drive(0, 1, 1, 21'h003210, 0, "R5");
        drive(0, 0, 1, 21'h003210, 0, "R4");
        drive(0, 1, 0, 21'h003211, 1, "R6");
        // R3 / R9: standby at both enable levels, address moving
        drive(1, 0, 1, 21'h055555, 0, "R3");
        drive(1, 1, 0, 21'h0AAAAA, 1, "R3");
        drive(1, 0, 1, 21'h1F0F0F, 0, "R9");
        drive(0, 0, 1, 21'h000042, 0, "R9");
        // R2: back-to-back mode and address changes
        for (int n = 0; n < 8; n++) begin
            drive(1'(n == 5), 1'(n % 3 == 0), 1'(n % 2), 21'(n * 21'h01357), 1'(n >> 1), "R2");
        end
        while (sb_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule